// File: doc/BRIEF.md
# Mid-Bit Sampling Serial Receiver

This block receives asynchronous serial frames on a single input line. An idle line is high. A falling edge arms a bit timer. The timer then produces exactly one sample point per bit period, placed at the centre of each bit. The first sample confirms that the start bit is still low. The data bits that follow are shifted in least significant bit first. The last sample checks the stop bit. No majority voting is done: each bit is sampled once.

Two configuration bytes set the timing. The low byte gives half the bit period in clock cycles, minus one. The high byte gives twice the number of data bits, minus one. Software reads the received word from a buffer and acknowledges it with a read strobe. Three flags report on each frame: a data-valid flag for a good word, an error flag for a bad stop bit or a break, and a one-cycle pulse when the stop bit is sampled.

Top module: `uart_rx_mid`

## Requirements
- R1: After reset, `rx_data`, `data_valid`, `err_flag` and `stop_flag` are all 0 and the receiver is idle.
- R2: A high-to-low transition of `rx` seen while idle starts a frame. With H = `frame_cfg[7:0]` + 1, the start bit is sampled H clock edges after the edge at which the low level is first seen. If that sample reads high, the frame is abandoned with no flag change, and the receiver waits for the next falling edge.
- R3: Each data bit is sampled once, 2·H clock edges after the previous sample. The bits fill the word least significant bit first.
- R4: The number of data bits is n = (`frame_cfg[15:8]` + 1) / 2, with 1 ≤ n ≤ DATA_W. The received bits are right-aligned in `rx_data`, and the bits above bit n-1 read 0.
- R5: `stop_flag` is high for exactly one cycle. That cycle follows the clock edge at which the stop bit is sampled, 2·H edges after the last data bit.
- R6: A stop bit sampled high loads the word into `rx_data` and sets `data_valid`.
- R7: A stop bit sampled low sets `err_flag` and loads `rx_data` with 0. A break (line held low through the stop position) therefore reads 0x00. `data_valid` is not set by such a frame.
- R8: A cycle with `rd` high clears `data_valid` and `err_flag`. If a stop sample sets a flag at the same edge, the set wins.
- R9: `rx_data` changes only at a stop-bit sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx | input | 1 | Serial line, idle high |
| frame_cfg | input | 2*CNT_W | [7:0] half bit period minus one; [15:8] twice the bit count minus one |
| rd | input | 1 | Buffer read acknowledge |
| rx_data | output | DATA_W | Received word |
| data_valid | output | 1 | Good word waiting in the buffer |
| err_flag | output | 1 | Stop bit sampled low |
| stop_flag | output | 1 | One-cycle pulse at each stop sample |

## Verification
The assertions assume two things about the inputs. First, `frame_cfg` stays constant for the whole of a frame. Second, the bit count it encodes lies between 1 and DATA_W. The stimulus changes the configuration only while the line is idle, between frames, and uses only legal bit counts. The stimulus covers 8-, 7- and 5-bit frames, a short glitch that must be abandoned, a framing error and a break. Read strobes run freely, so that some of them land on the same edge as a stop sample.

// File: rtl/uart_rx_mid.sv
module uart_rx_mid #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rx,
  input  logic [2*CNT_W-1:0] frame_cfg,
  input  logic               rd,
  output logic [DATA_W-1:0]  rx_data,
  output logic               data_valid,
  output logic               err_flag,
  output logic               stop_flag
);

  typedef enum logic [1:0] {IDLE, START, DATA, STOP} state_t;

  state_t            state;
  logic              rx_prev;
  logic [CNT_W:0]    cnt;
  logic [CNT_W:0]    bcnt;
  logic [DATA_W-1:0] shreg;

  wire [CNT_W-1:0] half_m1 = frame_cfg[CNT_W-1:0];
  wire [CNT_W:0]   full_m1 = {half_m1, 1'b1};
  wire [CNT_W:0]   nbits   = ({1'b0, frame_cfg[2*CNT_W-1:CNT_W]} + {{CNT_W{1'b0}}, 1'b1}) >> 1;
  wire             tick    = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= IDLE;
      rx_prev    <= 1'b1;
      cnt        <= '0;
      bcnt       <= '0;
      shreg      <= '0;
      rx_data    <= '0;
      data_valid <= 1'b0;
      err_flag   <= 1'b0;
      stop_flag  <= 1'b0;
    end else begin
      rx_prev   <= rx;
      stop_flag <= 1'b0;
      if (rd) begin
        data_valid <= 1'b0;
        err_flag   <= 1'b0;
      end
      if (state != IDLE && !tick) cnt <= cnt - 1'b1;
      case (state)
        IDLE: if (rx_prev && !rx) begin
          cnt   <= {1'b0, half_m1};
          state <= START;
        end
        START: if (tick) begin
          if (rx) state <= IDLE;
          else begin
            cnt   <= full_m1;
            bcnt  <= '0;
            state <= DATA;
          end
        end
        DATA: if (tick) begin
          shreg <= {rx, shreg[DATA_W-1:1]};
          bcnt  <= bcnt + 1'b1;
          cnt   <= full_m1;
          if (bcnt + 1'b1 == nbits) state <= STOP;
        end
        STOP: if (tick) begin
          stop_flag <= 1'b1;
          state     <= IDLE;
          if (rx) begin
            rx_data    <= DATA_W'(shreg >> (DATA_W - int'(nbits)));
            data_valid <= 1'b1;
          end else begin
            rx_data  <= '0;
            err_flag <= 1'b1;
          end
        end
        default: state <= IDLE;
      endcase
    end
  end

  // R5
  stop_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_flag |=> !stop_flag);
  // R6
  valid_needs_high_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_valid) |-> $past(rx) && stop_flag);
  // R7
  err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_flag) |-> (rx_data == '0) && !$past(rx) && stop_flag);
  // R8
  valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_valid && !rd) |=> data_valid);
  // R9
  data_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stop_flag |-> $stable(rx_data));

endmodule

// File: tb/tb_uart_rx_mid.sv
`timescale 1ns/1ps
module tb_uart_rx_mid;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx = 1'b1;
  logic [15:0] frame_cfg = 16'h0F01;
  logic rd = 1'b0;
  logic [7:0] rx_data;
  logic data_valid, err_flag, stop_flag;
  int checks = 0, errors = 0;
  bit rd_run = 0;
  bit done = 0;

  uart_rx_mid #(.DATA_W(8), .CNT_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .rx(rx), .frame_cfg(frame_cfg), .rd(rd),
    .rx_data(rx_data), .data_valid(data_valid), .err_flag(err_flag), .stop_flag(stop_flag));

  always #10 clk = ~clk;

  // behavioural reference
  int  age;
  bit  busy, prev;
  int  word;
  int  exp_data;
  bit  exp_valid, exp_err, exp_stop;
  int  stops_seen;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy = 0; prev = 1; word = 0; age = 0;
      exp_data = 0; exp_valid = 0; exp_err = 0; exp_stop = 0;
    end else begin
      automatic int h = int'(frame_cfg[7:0]) + 1;
      automatic int n = (int'(frame_cfg[15:8]) + 1) / 2;
      exp_stop = 0;
      if (rd) begin exp_valid = 0; exp_err = 0; end
      if (busy) begin
        age++;
        if (age == h) begin
          if (rx) busy = 0;
        end else if (age > h && (age - h) % (2*h) == 0) begin
          automatic int k = (age - h) / (2*h);
          if (k <= n) word |= int'(rx) << (k-1);
          else begin
            exp_stop = 1; stops_seen++;
            if (rx) begin exp_data = word; exp_valid = 1; end
            else begin exp_data = 0; exp_err = 1; end
            busy = 0;
          end
        end
      end else if (prev && !rx) begin
        busy = 1; age = 0; word = 0;
      end
      prev = rx;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk(rx_data == exp_data[7:0], "R6/R9 rx_data", rx_data, exp_data);
    chk(data_valid == exp_valid, "R6/R8 data_valid", data_valid, exp_valid);
    chk(err_flag == exp_err, "R7/R8 err_flag", err_flag, exp_err);
    chk(stop_flag == exp_stop, "R5 stop_flag", stop_flag, exp_stop);
  end

  initial begin : rd_gen
    forever begin
      repeat (23) @(negedge clk);
      if (rd_run) begin rd = 1'b1; @(negedge clk); rd = 1'b0; end
    end
  end

  task automatic idle(input int c);
    rx = 1'b1; repeat (c) @(negedge clk);
  endtask

  task automatic send(input int data, input int n, input int h, input bit stop_lvl);
    rx = 1'b0; repeat (2*h) @(negedge clk);
    for (int i = 0; i < n; i++) begin rx = data[i]; repeat (2*h) @(negedge clk); end
    rx = stop_lvl; repeat (2*h) @(negedge clk);
    idle(3*h);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(rx_data == 0 && !data_valid && !err_flag && !stop_flag, "R1 reset", {rx_data, data_valid, err_flag, stop_flag}, 0);
    rst_n = 1'b1;
    idle(5);
    // R3: 8 bits, H=2
    frame_cfg = 16'h0F01;
    send(8'hA5, 8, 2, 1);
    chk(rx_data == 8'hA5, "R3 lsb-first 8-bit", rx_data, 8'hA5);
    send(8'h3C, 8, 2, 1);
    chk(rx_data == 8'h3C && data_valid, "R3 second word", rx_data, 8'h3C);
    // R2: glitch shorter than half a bit is abandoned
    begin
      automatic int s0 = stops_seen;
      rx = 1'b0; @(negedge clk); idle(20);
      chk(stops_seen == s0 && rx_data == 8'h3C, "R2 glitch abort", rx_data, 8'h3C);
    end
    // R4: 7 bits H=3, 5 bits H=1
    frame_cfg = 16'h0D02;
    send(8'hFF, 7, 3, 1);
    chk(rx_data == 8'h7F, "R4 7-bit aligned", rx_data, 8'h7F);
    frame_cfg = 16'h0900;
    send(8'h16, 5, 1, 1);
    chk(rx_data == 8'h16, "R4 5-bit aligned", rx_data, 8'h16);
    // R7: framing error, then break
    frame_cfg = 16'h0F01;
    send(8'h5A, 8, 2, 0);
    chk(err_flag && rx_data == 0, "R7 framing error", rx_data, 0);
    rx = 1'b0; repeat (40) @(negedge clk); idle(10);
    chk(err_flag && rx_data == 0, "R7 break reads zero", rx_data, 0);
    // R8: read strobes running freely
    rd_run = 1;
    for (int i = 0; i < 12; i++) send((i * 37 + 11) & 8'hFF, 8, 2, (i % 4) != 3);
    rd_run = 0;
    @(negedge clk); rd = 1'b1; @(negedge clk); rd = 1'b0; @(negedge clk);
    chk(!data_valid && !err_flag, "R8 read clears", {data_valid, err_flag}, 0);
    idle(5);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule